// File: doc/BRIEF.md
# SPI Resynchronisation Reset Detector

This block sits behind the serial data pins of an SPI slave and looks for a request from the host to start over. It turns the serial stream into bytes (SPI mode 0: clock idles low, data is captured when the clock rises, most significant bit first). It also counts how many complete all-ones bytes have arrived back to back. Once a long enough run has been seen, the detector arms. It then waits for either of two events: the serial data line dropping low, or a timeout measured in system clock cycles. Whichever comes first triggers a one-cycle reset pulse.

The reset pulse loads every word of a small register file with the not-a-number pattern 32'h7FFFFFFF. During normal operation the register file accepts writes and reads through a plain port. The serial clock and data line are asynchronous to the system clock. Both pass through two-flop synchronisers, and bit capture runs on the rising edges of the synchronised serial clock.

Top module: `spi_resync_reset`

## Requirements
- R1: Each rising edge of the synchronised serial clock shifts in one bit, most significant bit first. After eight bits, `byte_valid` is high for exactly one system clock cycle and `byte_data` holds the byte until the next byte completes.
- R2: While not armed, `armed` goes high after RUN_LEN (default 9) consecutive received bytes equal to 8'hFF. It stays low after fewer than RUN_LEN.
- R3: While not armed, any received byte other than 8'hFF sets the consecutive count back to zero. A full new run of RUN_LEN 8'hFF bytes is then needed to arm.
- R4: While armed, a low level on the synchronised data line fires the reset. `reset_pulse` is high in the third system clock cycle after `sdi` falls. Sending an 8'h00 byte meets this condition. While not armed, a low data line never fires the reset.
- R5: While armed with the data line held high, the reset fires on its own exactly TIMEOUT_CYC system clock cycles after `armed` rises.
- R6: Extra 8'hFF bytes received while armed leave `armed` high and do not restart the timeout.
- R7: `reset_pulse` lasts one cycle. In the cycle it is high, `armed` is low and the run count is zero, so a new arming needs a full RUN_LEN run.
- R8: After `rst_n` and after every `reset_pulse`, every register file word reads 32'h7FFFFFFF.
- R9: When no reset fires, asserting `wr_en` stores `wr_data` at `wr_addr` on the clock edge. `rd_data` shows the word at `rd_addr` combinationally, and words that are not written keep their value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | SPI serial clock (mode 0, idles low) |
| sdi | input | 1 | SPI serial data into the block |
| byte_valid | output | 1 | One-cycle strobe when a byte completes |
| byte_data | output | 8 | Last completed byte |
| armed | output | 1 | Run of all-ones bytes seen, waiting to fire |
| reset_pulse | output | 1 | One-cycle reset strobe |
| wr_en | input | 1 | Register file write enable |
| wr_addr | input | $clog2(NUM_REGS) | Register file write address |
| wr_data | input | 32 | Register file write data |
| rd_addr | input | $clog2(NUM_REGS) | Register file read address |
| rd_data | output | 32 | Register file read data |

## Verification
Latencies are counted from the rising edge of `sclk` or the fall of `sdi`. The input sync is two flops, and one more register captures the bit or fires the reset. So `byte_valid` and `reset_pulse` appear in the third cycle, and `armed` one cycle after the last byte completes. The fall-to-pulse latency is checked at exactly the first, second, third and fourth cycles. The timeout is checked as an exact cycle difference between the rise of `armed` and the pulse, counted by a monitor on the falling clock edge. Byte, arming and register checks sample only after padding cycles that cover the full pipeline, and register reads are taken one cycle after the write edge.

// File: rtl/srr_pkg.sv
`timescale 1ns/1ps
package srr_pkg;
    localparam int unsigned BYTE_W        = 8;
    localparam int unsigned WORD_W        = 32;
    localparam logic [BYTE_W-1:0] ALL_ONES_BYTE = 8'hFF;
    localparam logic [WORD_W-1:0] NAN_WORD      = 32'h7FFF_FFFF;
endpackage

// File: rtl/srr_sync.sv
`timescale 1ns/1ps
module srr_sync #(
    parameter int unsigned     WIDTH   = 2,
    parameter int unsigned     STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [WIDTH-1:0] stage_q [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        logic [WIDTH-1:0] stage_d;
        if (g == 0) begin : g_first
            assign stage_d = async_i;
        end else begin : g_next
            assign stage_d = stage_q[g-1];
        end
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q[g] <= RST_VAL;
            else        stage_q[g] <= stage_d;
        end
    end

    assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/srr_deser.sv
`timescale 1ns/1ps
module srr_deser
    import srr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk_s_i,
    input  logic              sdi_s_i,
    output logic              byte_valid_o,
    output logic [BYTE_W-1:0] byte_o
);
    localparam int unsigned CNT_W = $clog2(BYTE_W);

    typedef struct packed {
        logic              sclk_prev;
        logic [CNT_W-1:0]  bit_cnt;
        logic [BYTE_W-1:0] shift;
        logic [BYTE_W-1:0] data;
        logic              valid;
    } deser_t;

    deser_t st_d, st_q;
    logic   rise;

    always_comb begin
        st_d           = st_q;
        st_d.valid     = 1'b0;
        st_d.sclk_prev = sclk_s_i;
        rise           = sclk_s_i && !st_q.sclk_prev;
        if (rise) begin
            st_d.shift   = {st_q.shift[BYTE_W-2:0], sdi_s_i};
            st_d.bit_cnt = st_q.bit_cnt + 1'b1;
            if (st_q.bit_cnt == CNT_W'(BYTE_W-1)) begin
                st_d.data    = {st_q.shift[BYTE_W-2:0], sdi_s_i};
                st_d.valid   = 1'b1;
                st_d.bit_cnt = '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign byte_valid_o = st_q.valid;
    assign byte_o       = st_q.data;

    // R1: a completed byte strobe is never two cycles long
    p_valid_single_r1: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.valid |=> !st_q.valid);
    // R1: a strobe only follows a captured rising edge
    p_valid_on_rise_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.valid) |-> $past(sclk_s_i) && !$past(st_q.sclk_prev));
endmodule

// File: rtl/srr_arm_fsm.sv
`timescale 1ns/1ps
module srr_arm_fsm
    import srr_pkg::*;
#(
    parameter int unsigned RUN_LEN     = 9,
    parameter int unsigned TIMEOUT_CYC = 5_000_000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              byte_valid_i,
    input  logic [BYTE_W-1:0] byte_i,
    input  logic              sdi_s_i,
    output logic              armed_o,
    output logic              fire_o
);
    localparam int unsigned RUN_W = $clog2(RUN_LEN + 1);
    localparam int unsigned TMO_W = $clog2(TIMEOUT_CYC + 1);

    typedef struct packed {
        logic [RUN_W-1:0] run;
        logic             armed;
        logic [TMO_W-1:0] tmo;
        logic             fire;
    } arm_t;

    arm_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.fire = 1'b0;
        if (st_q.armed) begin
            if (!sdi_s_i || st_q.tmo == TMO_W'(TIMEOUT_CYC - 1)) begin
                st_d.fire  = 1'b1;
                st_d.armed = 1'b0;
                st_d.run   = '0;
                st_d.tmo   = '0;
            end else begin
                st_d.tmo = st_q.tmo + 1'b1;
            end
        end else if (byte_valid_i) begin
            if (byte_i == ALL_ONES_BYTE) begin
                if (st_q.run == RUN_W'(RUN_LEN - 1)) begin
                    st_d.armed = 1'b1;
                    st_d.run   = '0;
                    st_d.tmo   = '0;
                end else begin
                    st_d.run = st_q.run + 1'b1;
                end
            end else begin
                st_d.run = '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign armed_o = st_q.armed;
    assign fire_o  = st_q.fire;

    p_run_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.run < RUN_W'(RUN_LEN));
    p_arm_from_ff_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.armed) |-> $past(byte_valid_i) && $past(byte_i) == ALL_ONES_BYTE);
    p_run_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.armed && byte_valid_i && byte_i != ALL_ONES_BYTE) |=> st_q.run == '0);
    p_fire_needs_arm_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.fire) |-> $past(st_q.armed));
    p_tmo_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.armed |-> st_q.tmo < TMO_W'(TIMEOUT_CYC));
    p_stay_armed_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.armed && sdi_s_i && st_q.tmo < TMO_W'(TIMEOUT_CYC - 1)) |=> st_q.armed);
    p_pulse_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.fire |=> !st_q.fire);
    p_fire_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.fire |-> !st_q.armed && st_q.run == '0);
endmodule

// File: rtl/srr_regfile.sv
`timescale 1ns/1ps
module srr_regfile
    import srr_pkg::*;
#(
    parameter int unsigned NUM_REGS = 8,
    localparam int unsigned ADDR_W  = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_i,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [WORD_W-1:0] wr_data_i,
    input  logic [ADDR_W-1:0] rd_addr_i,
    output logic [WORD_W-1:0] rd_data_o
);
    localparam logic [NUM_REGS-1:0][WORD_W-1:0] ALL_NAN = {NUM_REGS{NAN_WORD}};

    typedef struct packed {
        logic [NUM_REGS-1:0][WORD_W-1:0] mem;
    } rf_t;

    rf_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr_i) begin
            st_d.mem = ALL_NAN;
        end else if (wr_en_i && (32'(wr_addr_i) < NUM_REGS)) begin
            st_d.mem[wr_addr_i] = wr_data_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q.mem <= ALL_NAN;
        else        st_q     <= st_d;
    end

    assign rd_data_o = (32'(rd_addr_i) < NUM_REGS) ? st_q.mem[rd_addr_i] : '0;

    p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> st_q.mem == ALL_NAN);
    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_i && !wr_en_i) |=> $stable(st_q.mem));
endmodule

// File: rtl/spi_resync_reset.sv
`timescale 1ns/1ps
module spi_resync_reset
    import srr_pkg::*;
#(
    parameter int unsigned NUM_REGS    = 8,
    parameter int unsigned RUN_LEN     = 9,
    parameter int unsigned TIMEOUT_CYC = 5_000_000,
    localparam int unsigned ADDR_W     = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk,
    input  logic              sdi,
    output logic              byte_valid,
    output logic [BYTE_W-1:0] byte_data,
    output logic              armed,
    output logic              reset_pulse,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [WORD_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [WORD_W-1:0] rd_data
);
    logic [1:0] pins_s;
    logic       sclk_s;
    logic       sdi_s;

    srr_sync #(.WIDTH(2), .STAGES(2), .RST_VAL(2'b10)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({sdi, sclk}),
        .sync_o  (pins_s)
    );
    assign sclk_s = pins_s[0];
    assign sdi_s  = pins_s[1];

    srr_deser u_deser (
        .clk          (clk),
        .rst_n        (rst_n),
        .sclk_s_i     (sclk_s),
        .sdi_s_i      (sdi_s),
        .byte_valid_o (byte_valid),
        .byte_o       (byte_data)
    );

    srr_arm_fsm #(.RUN_LEN(RUN_LEN), .TIMEOUT_CYC(TIMEOUT_CYC)) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .byte_valid_i (byte_valid),
        .byte_i       (byte_data),
        .sdi_s_i      (sdi_s),
        .armed_o      (armed),
        .fire_o       (reset_pulse)
    );

    srr_regfile #(.NUM_REGS(NUM_REGS)) u_rf (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr_i     (reset_pulse),
        .wr_en_i   (wr_en),
        .wr_addr_i (wr_addr),
        .wr_data_i (wr_data),
        .rd_addr_i (rd_addr),
        .rd_data_o (rd_data)
    );
endmodule

// File: tb/spi_resync_reset_tb_top.sv
`timescale 1ns/1ps
module spi_resync_reset_tb_top;
    localparam int unsigned NREG = 8;
    localparam int unsigned RUNL = 9;
    localparam int unsigned TMO  = 400;
    localparam int unsigned HALF = 4;
    localparam logic [31:0] NAN  = 32'h7FFF_FFFF;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sclk = 1'b0;
    logic        sdi = 1'b1;
    logic        byte_valid;
    logic [7:0]  byte_data;
    logic        armed;
    logic        reset_pulse;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [2:0]  rd_addr = '0;
    logic [31:0] rd_data;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    int valid_cnt = 0;
    int pulse_cnt = 0;
    int double_cnt = 0;
    int arm_cyc = 0;
    int pulse_cyc = 0;
    logic armed_prev = 1'b0;
    logic pulse_prev = 1'b0;

    always #5 clk = ~clk;

    spi_resync_reset #(.NUM_REGS(NREG), .RUN_LEN(RUNL), .TIMEOUT_CYC(TMO)) dut_i (
        .clk(clk), .rst_n(rst_n), .sclk(sclk), .sdi(sdi),
        .byte_valid(byte_valid), .byte_data(byte_data),
        .armed(armed), .reset_pulse(reset_pulse),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data)
    );

    always @(negedge clk) begin
        cyc <= cyc + 1;
        if (byte_valid) valid_cnt <= valid_cnt + 1;
        if (reset_pulse) begin
            pulse_cnt <= pulse_cnt + 1;
            pulse_cyc <= cyc;
        end
        if (reset_pulse && pulse_prev) double_cnt <= double_cnt + 1;
        if (armed && !armed_prev) arm_cyc <= cyc;
        armed_prev <= armed;
        pulse_prev <= reset_pulse;
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic send_byte(input logic [7:0] b);
        for (int i = 7; i >= 0; i--) begin
            @(negedge clk) sdi = b[i];
            repeat (HALF) @(negedge clk);
            sclk = 1'b1;
            repeat (HALF) @(negedge clk);
            sclk = 1'b0;
        end
        repeat (8) @(negedge clk);
    endtask

    task automatic send_ff(input int n);
        for (int k = 0; k < n; k++) send_byte(8'hFF);
    endtask

    task automatic check_all_nan(input string req);
        for (int i = 0; i < NREG; i++) begin
            @(negedge clk) rd_addr = 3'(i);
            @(negedge clk) check(req, rd_data, NAN);
        end
    endtask

    task automatic fill_regs();
        for (int i = 0; i < NREG; i++) begin
            @(negedge clk) begin
                wr_en = 1'b1; wr_addr = 3'(i); wr_data = 32'h1000_0000 + 32'(i) * 32'h1111;
            end
        end
        @(negedge clk) wr_en = 1'b0;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        int p0;
        int c0;
        logic [7:0] brk [5];
        brk[0] = 8'h00; brk[1] = 8'h7F; brk[2] = 8'hFE; brk[3] = 8'h80; brk[4] = 8'hEF;

        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        check("R7 reset armed", {31'd0, armed}, 32'd0);
        check("R7 reset pulse", {31'd0, reset_pulse}, 32'd0);
        check("R1 reset valid", {31'd0, byte_valid}, 32'd0);
        check_all_nan("R8 after rst_n");

        // R9: write then read back every word
        fill_regs();
        for (int i = 0; i < NREG; i++) begin
            @(negedge clk) rd_addr = 3'(i);
            @(negedge clk) check("R9 readback", rd_data, 32'h1000_0000 + 32'(i) * 32'h1111);
        end

        // R1: exhaustive byte sweep
        for (int v = 0; v < 256; v++) begin
            c0 = valid_cnt;
            send_byte(8'(v));
            check("R1 byte value", {24'd0, byte_data}, 32'(v));
            check("R1 one strobe", 32'(valid_cnt - c0), 32'd1);
        end

        // R2: run-length sweep
        p0 = pulse_cnt;
        for (int n = 0; n < 12; n++) begin
            send_byte(8'h00);
            send_ff(n);
            check("R2 arm vs run length", {31'd0, armed}, (n >= RUNL) ? 32'd1 : 32'd0);
        end
        send_byte(8'h00);
        check("R2 fires per armed run", 32'(pulse_cnt - p0), 32'd3);

        // R3: interrupting bytes
        for (int k = 0; k < 5; k++) begin
            send_byte(8'h00);
            send_ff(RUNL - 1);
            send_byte(brk[k]);
            send_ff(RUNL - 1);
            check("R3 broken run not armed", {31'd0, armed}, 32'd0);
            send_ff(1);
            check("R3 full run arms", {31'd0, armed}, 32'd1);
            send_byte(8'h00);
            check("R3 disarmed after fire", {31'd0, armed}, 32'd0);
        end

        // R4: low data line while idle and not armed does nothing
        p0 = pulse_cnt;
        @(negedge clk) sdi = 1'b0;
        repeat (10) @(negedge clk);
        check("R4 no fire unarmed", 32'(pulse_cnt - p0), 32'd0);
        @(negedge clk) sdi = 1'b1;

        // R4: exact latency from sdi falling
        send_byte(8'h00);
        send_ff(RUNL);
        check("R4 armed before drop", {31'd0, armed}, 32'd1);
        @(negedge clk) sdi = 1'b0;
        @(negedge clk) check("R4 pulse cycle 1", {31'd0, reset_pulse}, 32'd0);
        @(negedge clk) check("R4 pulse cycle 2", {31'd0, reset_pulse}, 32'd0);
        @(negedge clk) check("R4 pulse cycle 3", {31'd0, reset_pulse}, 32'd1);
        @(negedge clk) check("R7 pulse gone cycle 4", {31'd0, reset_pulse}, 32'd0);
        check("R7 disarmed", {31'd0, armed}, 32'd0);
        @(negedge clk) sdi = 1'b1;

        // R4 and R8: 0x00 byte fires and clears the registers
        send_ff(RUNL);
        fill_regs();
        p0 = pulse_cnt;
        send_byte(8'h00);
        check("R4 zero byte fires", 32'(pulse_cnt - p0), 32'd1);
        check_all_nan("R8 after pulse");

        // R5: timeout with no extra bytes
        send_ff(RUNL);
        p0 = pulse_cnt;
        for (int w = 0; w < TMO + 50 && pulse_cnt == p0; w++) @(negedge clk);
        check("R5 timeout fired", 32'(pulse_cnt - p0), 32'd1);
        check("R5 timeout length", 32'(pulse_cyc - arm_cyc), 32'(TMO));

        // R7: after fire a full run is needed again
        send_ff(RUNL - 1);
        check("R7 count cleared", {31'd0, armed}, 32'd0);
        send_ff(1);
        check("R7 rearm", {31'd0, armed}, 32'd1);

        // R6: extra 0xFF bytes while armed
        p0 = pulse_cnt;
        send_ff(3);
        check("R6 still armed", {31'd0, armed}, 32'd1);
        check("R6 no early fire", 32'(pulse_cnt - p0), 32'd0);
        for (int w = 0; w < TMO + 50 && pulse_cnt == p0; w++) @(negedge clk);
        check("R6 timeout not restarted", 32'(pulse_cyc - arm_cyc), 32'(TMO));

        repeat (4) @(negedge clk);
        check("R7 single-cycle pulses", 32'(double_cnt), 32'd0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule